// File: doc/BRIEF.md
# Serial-Console Break Interrupt Arming Logic

This block sits between a 16-bit host bus and a dual-channel serial controller. It decodes host read and write cycles that fall inside the controller's register window into a channel select, a 4-bit register index and one-cycle read or write strobes toward the controller. The window is 128 bytes long. Registers sit only at even byte offsets, and the same 32 registers appear twice. Address bit 5 selects the channel and bits 4 to 1 select the register. Bit 6 only picks which copy of the registers is accessed.

The block also keeps a one-bit break-arm flag. A plain read in the upper channel-A copy of the registers sets the flag. A plain read in the upper channel-B copy clears it. While the flag is set, a low level on the console receive-data line raises a non-maskable interrupt request to the host. This lets a start bit typed at the console break into running software. The receive line is synchronised first. The request is a single-cycle pulse, and it is not raised again until the line has gone back high.

Top module: `console_break_glue`

## Requirements
- R1: A cycle with host_cs=1, host_rd=1, host_wr=0 and host_addr[0]=0 gives ctl_rd=1 for exactly the next clock cycle, with ctl_chan_a equal to host_addr[5] (1 = channel A, 0 = channel B) and ctl_reg_idx equal to host_addr[4:1].
- R2: The same cycle with host_wr=1 and host_rd=0 gives ctl_wr=1 for the next clock cycle, with the same channel and index decoding.
- R3: host_addr[6] has no effect on the channel or index presented to the controller. Offsets 0x40 to 0x7E address the same registers as 0x00 to 0x3E.
- R4: An access with host_addr[0]=1, or with host_rd and host_wr both high, produces no controller strobe and does not change the arm flag.
- R5: Without host_cs, host_rd and host_wr produce no controller strobe and do not change the arm flag.
- R6: A valid even read with host_addr[6:5]=2'b11 sets the arm flag.
- R7: A valid even read with host_addr[6:5]=2'b10 clears the arm flag.
- R8: Writes at any offset leave the arm flag unchanged.
- R9: While rst_n=0, ctl_rd, ctl_wr and nmi_req are 0 and the arm flag is cleared.
- R10: While the flag is armed and the line is idle high, a fall of con_rxd raises nmi_req for exactly one cycle, three clock edges after the fall (two synchroniser stages plus the output register).
- R11: After a pulse, nmi_req stays low until the synchronised con_rxd has been high for at least one cycle, however long the line stays low.
- R12: While the flag is clear, con_rxd low never raises nmi_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Window select from the host address decoder |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_addr | input | ADDR_W | Byte offset inside the window |
| con_rxd | input | 1 | Asynchronous console receive-data line, idle high |
| ctl_chan_a | output | 1 | Channel select to controller, 1 = A, 0 = B |
| ctl_reg_idx | output | REG_BITS | Register index to controller |
| ctl_rd | output | 1 | Read strobe to controller |
| ctl_wr | output | 1 | Write strobe to controller |
| nmi_req | output | 1 | Single-cycle non-maskable interrupt request |

## Verification
On every cycle the assertions check that strobes follow a qualified host access one cycle later with the right channel and index, and that odd or conflicting accesses never strobe. They also check that the two strobes are never both high, that an interrupt pulse lasts one cycle, and that each pulse follows a low receive line three edges earlier. Arming and disarming through mirror reads, the fact that writes do not touch the flag, clearing by reset, and the re-trigger block across a long low line all depend on hidden state. Only the bench's scenarios can show these, by probing the line and watching nmi_req.

// File: rtl/cbg_pkg.sv
// Shared types for the console break glue logic.
// Assumes the register window holds 2 channels x 2^REG_BITS registers at even offsets.
package cbg_pkg;

    localparam int DEF_REG_BITS = 4;
    localparam int DEF_ADDR_W   = DEF_REG_BITS + 3;
    localparam int DEF_SYNC     = 2;

    typedef enum logic {
        CH_B = 1'b0,
        CH_A = 1'b1
    } chan_e;

    typedef enum logic [1:0] {
        ARM_HOLD = 2'd0,
        ARM_SET  = 2'd1,
        ARM_CLR  = 2'd2
    } arm_cmd_e;

endpackage

// File: rtl/cbg_addr_decode.sv
// Combinational window decode.
// Qualifies host cycles (select, single strobe, even address) and splits the
// byte offset into channel, register index and an arm-flag command.
// Assumes ADDR_W >= REG_BITS + 3. Address bits above the mirror bit are ignored.
module cbg_addr_decode
    import cbg_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int REG_BITS = DEF_REG_BITS
) (
    input  logic                host_cs,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    output logic                acc_rd,
    output logic                acc_wr,
    output chan_e               acc_chan,
    output logic [REG_BITS-1:0] acc_idx,
    output arm_cmd_e            arm_cmd
);

    localparam int CHAN_BIT = REG_BITS + 1;
    localparam int MIR_BIT  = REG_BITS + 2;

    logic acc_ok;

    // Access qualification: selected, even offset, exactly one strobe.
    always_comb begin
        acc_ok = host_cs && !host_addr[0] && (host_rd ^ host_wr);
        acc_rd = acc_ok && host_rd;
        acc_wr = acc_ok && host_wr;
    end

    // Field split of the byte offset.
    always_comb begin
        acc_chan = host_addr[CHAN_BIT] ? CH_A : CH_B;
        acc_idx  = host_addr[REG_BITS:1];
    end

    // Arm command: only reads in the upper copy of the registers act on the flag.
    always_comb begin
        arm_cmd = ARM_HOLD;
        if (acc_rd && host_addr[MIR_BIT]) begin
            arm_cmd = host_addr[CHAN_BIT] ? ARM_SET : ARM_CLR;
        end
    end

endmodule

// File: rtl/cbg_ctl_port.sv
// Output register stage toward the serial controller.
// Presents strobes for one cycle after the host access, with index and channel held.
module cbg_ctl_port
    import cbg_pkg::*;
#(
    parameter int REG_BITS = DEF_REG_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_rd,
    input  logic                acc_wr,
    input  chan_e               acc_chan,
    input  logic [REG_BITS-1:0] acc_idx,
    output logic                ctl_chan_a,
    output logic [REG_BITS-1:0] ctl_reg_idx,
    output logic                ctl_rd,
    output logic                ctl_wr
);

    // Strobe register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_rd <= 1'b0;
            ctl_wr <= 1'b0;
        end else begin
            ctl_rd <= acc_rd;
            ctl_wr <= acc_wr;
        end
    end

    // Address fields load only with an accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_chan_a  <= 1'b0;
            ctl_reg_idx <= '0;
        end else if (acc_rd || acc_wr) begin
            ctl_chan_a  <= (acc_chan == CH_A);
            ctl_reg_idx <= acc_idx;
        end
    end

endmodule

// File: rtl/cbg_arm_ctrl.sv
// Break-arm flag.
// Set and cleared by decoded read commands, cleared by reset.
module cbg_arm_ctrl
    import cbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  arm_cmd_e arm_cmd,
    output logic     armed
);

    // Flag update from the decoded command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            unique case (arm_cmd)
                ARM_SET: armed <= 1'b1;
                ARM_CLR: armed <= 1'b0;
                default: armed <= armed;
            endcase
        end
    end

endmodule

// File: rtl/cbg_sync.sv
// Multi-stage synchroniser for an asynchronous level, reset to idle-high.
// Assumes STAGES >= 1. Output follows input after STAGES clock edges.
module cbg_sync #(
    parameter int   STAGES   = cbg_pkg::DEF_SYNC,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single-stage capture.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d_async;
            end
        end else begin : g_many
            // Shift chain capture.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cbg_nmi_gen.sv
// NMI pulse generator.
// Raises a one-cycle pulse when armed and the synchronised line is low, then
// blocks further pulses until the line has been seen high again.
module cbg_nmi_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic rxd_s,
    output logic nmi_req
);

    logic blocked;
    logic fire;

    // Fire condition from the current flag, line level and block state.
    always_comb fire = armed && !rxd_s && !blocked;

    // Block latch: set on a pulse, released by a high line.
    always_ff @(posedge clk) begin
        if (!rst_n)       blocked <= 1'b0;
        else if (rxd_s)   blocked <= 1'b0;
        else if (fire)    blocked <= 1'b1;
    end

    // Registered request output.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_req <= 1'b0;
        else        nmi_req <= fire;
    end

endmodule

// File: rtl/console_break_glue.sv
// Top: host-bus glue for a dual-channel serial controller with console break arming.
// Assumes one-cycle host strobes and a host_cs already decoded for the window.
module console_break_glue
    import cbg_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int REG_BITS    = DEF_REG_BITS,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_cs,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic                con_rxd,
    output logic                ctl_chan_a,
    output logic [REG_BITS-1:0] ctl_reg_idx,
    output logic                ctl_rd,
    output logic                ctl_wr,
    output logic                nmi_req
);

    logic                acc_rd;
    logic                acc_wr;
    chan_e               acc_chan;
    logic [REG_BITS-1:0] acc_idx;
    arm_cmd_e            arm_cmd;
    logic                armed;
    logic                rxd_s;

    cbg_addr_decode #(.ADDR_W(ADDR_W), .REG_BITS(REG_BITS)) u_dec (
        .host_cs   (host_cs),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .acc_chan  (acc_chan),
        .acc_idx   (acc_idx),
        .arm_cmd   (arm_cmd)
    );

    cbg_ctl_port #(.REG_BITS(REG_BITS)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_rd      (acc_rd),
        .acc_wr      (acc_wr),
        .acc_chan    (acc_chan),
        .acc_idx     (acc_idx),
        .ctl_chan_a  (ctl_chan_a),
        .ctl_reg_idx (ctl_reg_idx),
        .ctl_rd      (ctl_rd),
        .ctl_wr      (ctl_wr)
    );

    cbg_arm_ctrl u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_cmd (arm_cmd),
        .armed   (armed)
    );

    cbg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (con_rxd),
        .q_sync  (rxd_s)
    );

    cbg_nmi_gen u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed),
        .rxd_s   (rxd_s),
        .nmi_req (nmi_req)
    );

endmodule

// File: rtl/cbg_checker.sv
// Port-level property checker for console_break_glue, attached by bind.
module cbg_checker #(
    parameter int ADDR_W   = cbg_pkg::DEF_ADDR_W,
    parameter int REG_BITS = cbg_pkg::DEF_REG_BITS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_cs,
    input logic                host_rd,
    input logic                host_wr,
    input logic [ADDR_W-1:0]   host_addr,
    input logic                con_rxd,
    input logic                ctl_chan_a,
    input logic [REG_BITS-1:0] ctl_reg_idx,
    input logic                ctl_rd,
    input logic                ctl_wr,
    input logic                nmi_req
);

    localparam int CHAN_BIT = REG_BITS + 1;

    logic good_acc;
    assign good_acc = host_cs && !host_addr[0] && (host_rd != host_wr);

    p_rd_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (good_acc && host_rd) |=> (ctl_rd && !ctl_wr));

    p_wr_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (good_acc && host_wr) |=> (ctl_wr && !ctl_rd));

    p_chan_r1: assert property (@(posedge clk) disable iff (!rst_n)
        good_acc |=> (ctl_chan_a == $past(host_addr[CHAN_BIT])));

    p_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        good_acc |=> (ctl_reg_idx == $past(host_addr[REG_BITS:1])));

    p_odd_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr[0] || (host_rd && host_wr)) |=> (!ctl_rd && !ctl_wr));

    p_no_cs_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cs |=> (!ctl_rd && !ctl_wr));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_rd && ctl_wr));

    p_nmi_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    p_nmi_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> !$past(con_rxd, 3));

endmodule

bind console_break_glue cbg_checker #(.ADDR_W(ADDR_W), .REG_BITS(REG_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_cs     (host_cs),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .con_rxd     (con_rxd),
    .ctl_chan_a  (ctl_chan_a),
    .ctl_reg_idx (ctl_reg_idx),
    .ctl_rd      (ctl_rd),
    .ctl_wr      (ctl_wr),
    .nmi_req     (nmi_req)
);

// File: tb/sim_console_break_glue.sv
`timescale 1ns/1ps
module sim_console_break_glue;

    localparam int ADDR_W   = 7;
    localparam int REG_BITS = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                host_cs = 1'b0;
    logic                host_rd = 1'b0;
    logic                host_wr = 1'b0;
    logic [ADDR_W-1:0]   host_addr = '0;
    logic                con_rxd = 1'b1;
    logic                ctl_chan_a;
    logic [REG_BITS-1:0] ctl_reg_idx;
    logic                ctl_rd;
    logic                ctl_wr;
    logic                nmi_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    console_break_glue #(.ADDR_W(ADDR_W), .REG_BITS(REG_BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
        .host_wr(host_wr), .host_addr(host_addr), .con_rxd(con_rxd),
        .ctl_chan_a(ctl_chan_a), .ctl_reg_idx(ctl_reg_idx),
        .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .nmi_req(nmi_req)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One host cycle; outputs are checked half a period after the capturing edge.
    task automatic access(string req, bit cs, bit rd, bit wr, int addr,
                          bit exp_rd, bit exp_wr);
        @(negedge clk);
        host_cs = cs; host_rd = rd; host_wr = wr; host_addr = addr[ADDR_W-1:0];
        @(negedge clk);
        host_cs = 0; host_rd = 0; host_wr = 0;
        chk({req, " rd strobe"}, ctl_rd, exp_rd);
        chk({req, " wr strobe"}, ctl_wr, exp_wr);
        if (exp_rd || exp_wr) begin
            chk({req, " channel"}, ctl_chan_a, (addr >> 5) & 1);
            chk({req, " index"}, ctl_reg_idx, (addr >> 1) & 15);
        end
        @(negedge clk);
        chk({req, " strobe one cycle"}, ctl_rd | ctl_wr, 0);
    endtask

    // Pull the line low and count pulses; a pulse is expected on the third edge.
    task automatic nmi_probe(string req, bit exp);
        int seen = 0;
        int at = -1;
        @(negedge clk);
        con_rxd = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (nmi_req) begin seen++; at = i; end
        end
        chk({req, " pulse count"}, seen, exp ? 1 : 0);
        if (exp) chk({req, " pulse edge"}, at, 3);
        con_rxd = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R9 reset ctl_rd", ctl_rd, 0);
        chk("R9 reset ctl_wr", ctl_wr, 0);
        chk("R9 reset nmi", nmi_req, 0);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_read_decode();
        access("R1 B0", 1, 1, 0, 'h00, 1, 0);
        access("R1 B15", 1, 1, 0, 'h1E, 1, 0);
        access("R1 A0", 1, 1, 0, 'h20, 1, 0);
        access("R1 A15", 1, 1, 0, 'h3E, 1, 0);
        access("R3 mirror B13", 1, 1, 0, 'h5A, 1, 0);
    endtask

    task automatic t_write_decode();
        access("R2 A5", 1, 0, 1, 'h2A, 0, 1);
        access("R2 B3", 1, 0, 1, 'h06, 0, 1);
        access("R3 mirror A7", 1, 0, 1, 'h6E, 0, 1);
    endtask

    task automatic t_ignored();
        access("R4 odd read", 1, 1, 0, 'h23, 0, 0);
        access("R4 odd write", 1, 0, 1, 'h61, 0, 0);
        access("R4 both strobes", 1, 1, 1, 'h20, 0, 0);
        access("R5 no select", 0, 1, 0, 'h24, 0, 0);
    endtask

    task automatic t_arm();
        nmi_probe("R12 idle disarmed", 0);
        access("R6 arm read", 1, 1, 0, 'h60, 1, 0);
        nmi_probe("R6 armed pulse", 1);
        access("R8 write at disarm offset", 1, 0, 1, 'h40, 0, 1);
        nmi_probe("R8 still armed", 1);
        access("R4 odd read at disarm offset", 1, 1, 0, 'h41, 0, 0);
        nmi_probe("R4 still armed", 1);
        access("R7 disarm read", 1, 1, 0, 'h44, 1, 0);
        nmi_probe("R7 disarmed", 0);
        access("R8 write at arm offset", 1, 0, 1, 'h62, 0, 1);
        nmi_probe("R8 still disarmed", 0);
        access("R5 unselected arm read", 0, 1, 0, 'h60, 0, 0);
        nmi_probe("R5 still disarmed", 0);
        access("R3 lower copy no arm", 1, 1, 0, 'h20, 1, 0);
        nmi_probe("R3 lower copy", 0);
    endtask

    task automatic t_hold_low();
        int cnt = 0;
        access("R6 arm again", 1, 1, 0, 'h7E, 1, 0);
        @(negedge clk);
        con_rxd = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (nmi_req) cnt++;
        end
        chk("R11 long low single pulse", cnt, 1);
        con_rxd = 1;
        repeat (3) @(negedge clk);
        chk("R11 quiet after release", nmi_req, 0);
        nmi_probe("R11 re-trigger after high", 1);
    endtask

    task automatic t_reset_disarms();
        do_reset();
        nmi_probe("R9 disarmed by reset", 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset ctl_rd", ctl_rd, 0);
        chk("R9 reset ctl_wr", ctl_wr, 0);
        chk("R9 reset nmi", nmi_req, 0);
        rst_n = 1;
        @(negedge clk);
        t_read_decode();
        t_write_decode();
        t_ignored();
        t_arm();
        t_hold_low();
        t_reset_disarms();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule